// File: doc/BRIEF.md
# Contiguous Free-Run Allocator

This block keeps one bit per translation entry across a single occupancy vector and hands out runs of consecutive free entries. A request carries a byte start address, a byte length and a pool selector. The block turns the address span into a page count for the page size of that pool. It then scans the pool's slice of the vector first-fit, testing one candidate start per clock. It marks the winning run as used and returns its start index and length, or it reports failure. A separate release port clears any run by index and count. Writing entry contents and keeping a list of mappings are done elsewhere.

The vector is carved into four windows. Two are dedicated to individual ports and use very large pages. One shared window uses small pages. One wide window uses medium pages. A map agent asks for a window, gets back a global entry index, and later frees the same index and count.

Request and response use valid/ready. A request is taken only when `req_ready` is high, which is only while the block is idle. A response stays on the pins, unchanged, until `resp_ready` is seen high on a clock edge. No new request is taken before that. Releases have no handshake and are applied in the cycle they are presented.

Top module: `rr_run_alloc`

## Requirements
- R1: The page count is ((start + length − 1) >> shift) − (start >> shift) + 1, so an unaligned span that crosses page boundaries takes every page it touches.
- R2: Pool selector encodings are: 0 = shared window, entries 64..127, 256 KB pages (shift 18); 1 = wide window, entries 128..159, 64 MB pages (shift 26); 2 = port-0 super window, entries 0..31, 16 GB pages (shift 34); 3 = port-1 super window, entries 32..63, 16 GB pages. Returned indices are global.
- R3: A request whose page count exceeds its window size, or whose length is zero, fails without any search.
- R4: The search is first fit: the returned start is the lowest index in the window at which `count` consecutive entries are all free.
- R5: On success every entry of the run becomes used, and later requests do not receive any of those entries.
- R6: No candidate start beyond (window first + window size − count) is tried; when no run fits, the response is a failure and no entry outside the window is ever granted.
- R7: A release with index i and count c makes entries i..i+c−1 free again.
- R8: A release presented in the same cycle as an accepted request takes effect before that request's search starts.
- R9: `req_ready` is high only when idle with no pending response, and `busy` is high while scanning. A response holds `resp_ok`, `resp_idx` and `resp_count` stable until taken with `resp_ready`.
- R10: After reset all entries are free, `req_ready` is 1 and `resp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Allocation request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_pool | input | 2 | Window selector (see R2) |
| req_start | input | ADDR_W (48) | Byte start address |
| req_len | input | LEN_W (40) | Byte length |
| rel_valid | input | 1 | Release strobe |
| rel_idx | input | IDX_W (8) | First entry to free |
| rel_count | input | IDX_W (8) | Number of entries to free |
| busy | output | 1 | Scan in progress |
| resp_valid | output | 1 | Response pending |
| resp_ready | input | 1 | Response consumed |
| resp_ok | output | 1 | 1 = run granted, 0 = failure |
| resp_idx | output | IDX_W (8) | Granted global start index |
| resp_count | output | IDX_W (8) | Granted page count |

## Verification
A release and an allocation can land in the same clock edge. They meet either when a request is accepted or when a scan marks its run while a release clears entries. The bench first fills a port window until a request fails. It then presents a release of that whole run on the very edge that accepts an identical request. The request must succeed at the freed index, which shows that the clear was applied ahead of the search.

// File: rtl/rr_pkg.sv
package rr_pkg;
  typedef enum logic [1:0] {
    POOL_SHARED = 2'd0,
    POOL_WIDE   = 2'd1,
    POOL_SUPER0 = 2'd2,
    POOL_SUPER1 = 2'd3
  } pool_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_RESP   = 2'd2
  } state_e;
endpackage

// File: rtl/rr_pool_map.sv
module rr_pool_map #(
  parameter int SUPER_RUN    = 32,
  parameter int SHARED_END   = 128,
  parameter int WIDE_ENTRIES = 32,
  parameter int SHIFT_SHARED = 18,
  parameter int SHIFT_WIDE   = 26,
  parameter int SHIFT_SUPER  = 34,
  parameter int IDX_W        = 8
) (
  input  rr_pkg::pool_e     pool,
  output logic [IDX_W-1:0]  first,
  output logic [IDX_W-1:0]  entries,
  output logic [5:0]        shift
);
  localparam int SHARED_FIRST = 2 * SUPER_RUN;
  localparam int SHARED_SIZE  = SHARED_END - SHARED_FIRST;

  always_comb begin
    unique case (pool)
      rr_pkg::POOL_SHARED: begin
        first   = IDX_W'(SHARED_FIRST);
        entries = IDX_W'(SHARED_SIZE);
        shift   = 6'(SHIFT_SHARED);
      end
      rr_pkg::POOL_WIDE: begin
        first   = IDX_W'(SHARED_END);
        entries = IDX_W'(WIDE_ENTRIES);
        shift   = 6'(SHIFT_WIDE);
      end
      rr_pkg::POOL_SUPER0: begin
        first   = '0;
        entries = IDX_W'(SUPER_RUN);
        shift   = 6'(SHIFT_SUPER);
      end
      default: begin
        first   = IDX_W'(SUPER_RUN);
        entries = IDX_W'(SUPER_RUN);
        shift   = 6'(SHIFT_SUPER);
      end
    endcase
  end
endmodule

// File: rtl/rr_page_calc.sv
module rr_page_calc #(
  parameter int ADDR_W = 48,
  parameter int LEN_W  = 40,
  parameter int IDX_W  = 8
) (
  input  logic [ADDR_W-1:0] start,
  input  logic [LEN_W-1:0]  len,
  input  logic [5:0]        shift,
  input  logic [IDX_W-1:0]  entries,
  output logic [IDX_W-1:0]  count,
  output logic              too_big
);
  logic [ADDR_W:0] end_byte;
  logic [ADDR_W:0] pg_lo;
  logic [ADDR_W:0] pg_hi;
  logic [ADDR_W:0] span;

  always_comb begin
    end_byte = {1'b0, start} + (ADDR_W+1)'(len) - (ADDR_W+1)'(1);
    pg_lo    = {1'b0, start} >> shift;
    pg_hi    = end_byte >> shift;
    span     = pg_hi - pg_lo;
    too_big  = (len == '0) || (span >= (ADDR_W+1)'(entries));
    count    = span[IDX_W-1:0] + IDX_W'(1);
  end
endmodule

// File: rtl/rr_span_mask.sv
module rr_span_mask #(
  parameter int N     = 160,
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0] base,
  input  logic [IDX_W-1:0] len,
  output logic [N-1:0]     mask
);
  logic [IDX_W:0] lim;
  assign lim = {1'b0, base} + {1'b0, len};

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign mask[i] = ((IDX_W+1)'(i) >= {1'b0, base}) && ((IDX_W+1)'(i) < lim);
  end
endmodule

// File: rtl/rr_run_alloc.sv
module rr_run_alloc #(
  parameter int SUPER_RUN    = 32,
  parameter int SHARED_END   = 128,
  parameter int WIDE_ENTRIES = 32,
  parameter int ADDR_W       = 48,
  parameter int LEN_W        = 40,
  parameter int SHIFT_SHARED = 18,
  parameter int SHIFT_WIDE   = 26,
  parameter int SHIFT_SUPER  = 34,
  localparam int TOTAL       = SHARED_END + WIDE_ENTRIES,
  localparam int IDX_W       = $clog2(TOTAL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_pool,
  input  logic [ADDR_W-1:0] req_start,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              rel_valid,
  input  logic [IDX_W-1:0]  rel_idx,
  input  logic [IDX_W-1:0]  rel_count,
  output logic              busy,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic              resp_ok,
  output logic [IDX_W-1:0]  resp_idx,
  output logic [IDX_W-1:0]  resp_count
);
  import rr_pkg::*;

  state_e           state;
  logic [TOTAL-1:0] used;
  logic [IDX_W-1:0] cand;
  logic [IDX_W-1:0] cand_last;
  logic [IDX_W-1:0] run_len;
  logic             ok_q;

  logic [IDX_W-1:0] win_first;
  logic [IDX_W-1:0] win_size;
  logic [5:0]       pg_shift;
  logic [IDX_W-1:0] pg_count;
  logic             pg_too_big;
  logic [TOTAL-1:0] cand_mask;
  logic [TOTAL-1:0] rel_mask;
  logic             cand_free;
  logic             accept;
  logic             grant;

  rr_pool_map #(
    .SUPER_RUN(SUPER_RUN), .SHARED_END(SHARED_END), .WIDE_ENTRIES(WIDE_ENTRIES),
    .SHIFT_SHARED(SHIFT_SHARED), .SHIFT_WIDE(SHIFT_WIDE), .SHIFT_SUPER(SHIFT_SUPER),
    .IDX_W(IDX_W)
  ) u_map (
    .pool(pool_e'(req_pool)), .first(win_first), .entries(win_size), .shift(pg_shift)
  );

  rr_page_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_pages (
    .start(req_start), .len(req_len), .shift(pg_shift), .entries(win_size),
    .count(pg_count), .too_big(pg_too_big)
  );

  rr_span_mask #(.N(TOTAL), .IDX_W(IDX_W)) u_cand_mask (
    .base(cand), .len(run_len), .mask(cand_mask)
  );

  rr_span_mask #(.N(TOTAL), .IDX_W(IDX_W)) u_rel_mask (
    .base(rel_idx), .len(rel_count), .mask(rel_mask)
  );

  assign req_ready  = (state == ST_IDLE);
  assign busy       = (state == ST_SEARCH);
  assign resp_valid = (state == ST_RESP);
  assign resp_ok    = ok_q;
  assign resp_idx   = cand;
  assign resp_count = run_len;

  assign accept    = req_valid && req_ready;
  assign cand_free = ~|(used & cand_mask);
  assign grant     = (state == ST_SEARCH) && cand_free;

  // Release clears first; a grant in the same edge then sets its run.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used <= '0;
    end else begin
      used <= (used & ~(rel_valid ? rel_mask : '0)) | (grant ? cand_mask : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cand      <= '0;
      cand_last <= '0;
      run_len   <= '0;
      ok_q      <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            cand      <= win_first;
            cand_last <= win_first + win_size - pg_count;
            run_len   <= pg_count;
            ok_q      <= 1'b0;
            state     <= pg_too_big ? ST_RESP : ST_SEARCH;
          end
        end
        ST_SEARCH: begin
          if (cand_free) begin
            ok_q  <= 1'b1;
            state <= ST_RESP;
          end else if (cand == cand_last) begin
            ok_q  <= 1'b0;
            state <= ST_RESP;
          end else begin
            cand <= cand + IDX_W'(1);
          end
        end
        ST_RESP: begin
          if (resp_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rr_run_alloc_chk.sv
module rr_run_alloc_chk #(
  parameter int TOTAL = 160,
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             busy,
  input logic             resp_valid,
  input logic             resp_ready,
  input logic             resp_ok,
  input logic [IDX_W-1:0] resp_idx,
  input logic [IDX_W-1:0] resp_count
);
  // R9: idle, scanning and responding never overlap
  assert_one_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({req_ready, busy, resp_valid}) == 1);

  // R9: an accepted request closes the request port on the next cycle
  assert_accept_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R9: a pending response is held unchanged while not taken
  assert_resp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=>
      (resp_valid && $stable(resp_ok) && $stable(resp_idx) && $stable(resp_count)));

  // R6: a granted run lies inside the vector and is non-empty
  assert_grant_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_ok) |->
      (resp_count != '0) && (({1'b0, resp_idx} + {1'b0, resp_count}) <= (IDX_W+1)'(TOTAL)));

  // R10: the block leaves reset idle
  assert_reset_idle_R10: assert property (@(posedge clk)
    $rose(rst_n) |-> (req_ready && !resp_valid));
endmodule

bind rr_run_alloc rr_run_alloc_chk #(.TOTAL(TOTAL), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .resp_valid(resp_valid), .resp_ready(resp_ready),
  .resp_ok(resp_ok), .resp_idx(resp_idx), .resp_count(resp_count)
);

// File: tb/rr_run_alloc_bench.sv
module rr_run_alloc_bench;
  localparam int IDX_W = 8;
  localparam logic [1:0] P_SH = 2'd0, P_WD = 2'd1, P_S0 = 2'd2, P_S1 = 2'd3;
  localparam logic [47:0] PG_SH = 48'h40000;
  localparam logic [39:0] PG_WD = 40'h4000000;
  localparam logic [39:0] PG_SU = 40'h400000000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_pool = '0;
  logic [47:0] req_start = '0;
  logic [39:0] req_len = '0;
  logic rel_valid = 1'b0;
  logic [IDX_W-1:0] rel_idx = '0, rel_count = '0;
  logic busy, resp_valid, resp_ok;
  logic resp_ready = 1'b0;
  logic [IDX_W-1:0] resp_idx, resp_count;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  rr_run_alloc u_rr_run_alloc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_pool(req_pool), .req_start(req_start), .req_len(req_len),
    .rel_valid(rel_valid), .rel_idx(rel_idx), .rel_count(rel_count),
    .busy(busy), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_ok(resp_ok), .resp_idx(resp_idx), .resp_count(resp_count)
  );

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic release_run(int idx, int cnt);
    @(negedge clk);
    rel_valid = 1'b1; rel_idx = IDX_W'(idx); rel_count = IDX_W'(cnt);
    @(negedge clk);
    rel_valid = 1'b0;
  endtask

  task automatic alloc(string tag, logic [1:0] pool, logic [47:0] st, logic [39:0] ln,
                       bit eok, int eidx, int ecnt,
                       bit with_rel = 0, int ri = 0, int rc = 0, int hold = 0);
    @(negedge clk);
    req_valid = 1'b1; req_pool = pool; req_start = st; req_len = ln;
    if (with_rel) begin
      rel_valid = 1'b1; rel_idx = IDX_W'(ri); rel_count = IDX_W'(rc);
    end
    @(negedge clk);
    req_valid = 1'b0; rel_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    check({tag, " ok"}, resp_ok, eok);
    if (eok) begin
      check({tag, " idx"}, resp_idx, eidx);
      check({tag, " count"}, resp_count, ecnt);
    end
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check({tag, " R9 held valid"}, resp_valid, 1);
      check({tag, " R9 req_ready low"}, req_ready, 0);
      check({tag, " R9 idx stable"}, resp_idx, eidx);
    end
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
  endtask

  task automatic t_reset;
    check("R10 req_ready", req_ready, 1);
    check("R10 resp_valid", resp_valid, 0);
    check("R10 busy", busy, 0);
  endtask

  task automatic t_page_span;
    alloc("R1 unaligned two pages", P_SH, 48'h3FFFF, 40'd2, 1, 64, 2);
    alloc("R1 exact one page", P_SH, 48'h40000, 40'h40000, 1, 66, 1);
  endtask

  task automatic t_pools;
    alloc("R2 super port1", P_S1, 48'h0, 40'd1, 1, 32, 1);
    alloc("R2 super port0", P_S0, 48'h0, 40'd1, 1, 0, 1);
    alloc("R2 wide three", P_WD, 48'h0, 3 * PG_WD, 1, 128, 3);
    alloc("R1 wide straddle", P_WD, 48'h3FFFFFF, 40'd2, 1, 131, 2);
  endtask

  task automatic t_too_big;
    alloc("R3 super oversize", P_S0, 48'h0, 33 * PG_SU, 0, 0, 0);
    alloc("R3 zero length", P_SH, 48'h0, 40'd0, 0, 0, 0);
    alloc("R3 wide oversize", P_WD, 48'h0, 33 * PG_WD, 0, 0, 0);
  endtask

  task automatic t_first_fit;
    // used: 64,65,66
    release_run(65, 1);
    alloc("R7 freed slot reused", P_SH, 48'h0, 40'd1, 1, 65, 1);
    release_run(64, 3);
    alloc("R4 lowest fit", P_SH, 48'h0, 40'(3 * PG_SH), 1, 64, 3);
    alloc("R5 run avoided", P_SH, 48'h0, 40'(2 * PG_SH), 1, 67, 2);
    release_run(65, 1);
    alloc("R4 skip short hole", P_SH, 48'h0, 40'(2 * PG_SH), 1, 69, 2);
    alloc("R4 fill hole", P_SH, 48'h0, 40'd1, 1, 65, 1);
  endtask

  task automatic t_exhaust;
    alloc("R5 super0 rest", P_S0, 48'h0, 31 * PG_SU, 1, 1, 31);
    alloc("R6 super0 full", P_S0, 48'h0, 40'd1, 0, 0, 0);
    alloc("R6 port1 unaffected", P_S1, 48'h0, 40'd1, 1, 33, 1);
    alloc("R5 wide rest", P_WD, 48'h0, 27 * PG_WD, 1, 133, 27);
    alloc("R6 wide full", P_WD, 48'h0, 40'd1, 0, 0, 0);
  endtask

  task automatic t_same_cycle;
    alloc("R8 release then alloc", P_S0, 48'h0, 31 * PG_SU, 1, 1, 31, 1, 1, 31);
  endtask

  task automatic t_backpressure;
    alloc("R9 stall", P_S1, 48'h0, 40'd1, 1, 34, 1, 0, 0, 0, 4);
    check("R9 ready after take", req_ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_page_span();
    t_pools();
    t_too_big();
    t_first_fit();
    t_exhaust();
    t_same_cycle();
    t_backpressure();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule